// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers up to thirteen level-sensitive interrupt request lines into a pending register. It removes every request whose mask bit is set. Among the requests that remain, it picks the one with the highest priority. Each source has an 8-bit control register. That register holds a 5-bit priority value whose upper three bits are also the interrupt level presented to the processor, and a flag that chooses how the vector number is formed.

The processor sees a registered 3-bit level and an 8-bit vector number. Level 0 means that no interrupt is requested. A source can use an autovector, which is a fixed base plus its level. Otherwise it takes its vector from a dedicated register: one software vector register and two serial-port vector registers are provided. Sources without a dedicated register fall back to vector 0x0F. Software reaches the control, mask, pending and vector registers through a simple synchronous register port. Reads from that port are combinational.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset both outputs are 0, and reads return the reset values. The control register for source n sits at address n (1..13) and resets to 04, 08, 0C, 10, 14, 18, 1C for sources 1 to 7. Source 8 resets to 1C, sources 9 to 11 to 80, and sources 12 and 13 to 00 (hex). The mask register at address 0x10 reads 0x3FFE. The vector registers at 0x12, 0x13 and 0x14 read 0x0F.
- R2: The pending register at address 0x11 holds, in bit n, request line n as sampled on the previous clock edge. Bit 0 reads 0.
- R3: Mask bit n (register 0x10, written from write-data bit n) set to 1 blocks source n. When no pending source is unmasked, the level is 0.
- R4: Among active sources, the winner has the largest control bits 4:0.
- R5: When two active sources have equal bits 4:0, the lower-numbered source wins.
- R6: If the winner's bits 4:0 are below 4, the level and the vector are both 0, whatever bit 7 holds.
- R7: The output level equals control bits 4:2 of the winner.
- R8: If the winner's control bit 7 is 1, the vector is 24 plus the level.
- R9: If bit 7 is 0, source 8 takes its vector from register 0x12, source 12 from register 0x13 and source 13 from register 0x14.
- R10: If bit 7 is 0 and the winner is any other source, the vector is 0x0F.
- R11: The outputs change one clock edge after a write to a control, mask or vector register takes effect. A change on a request line reaches the outputs on the second edge.
- R12: Writes to address 0, to the pending address or to addresses above 0x14 change nothing. Reads from address 0 and from addresses above 0x14 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | 13 | Request lines, bit n is source n (bits 13:1) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| int_level | output | 3 | Requested interrupt level, 0 for none |
| int_vector | output | 8 | Vector number for the requested level |

## Verification
A register write is captured on one edge, and the level and vector that follow from it appear on the next edge. A request line takes one more edge to reach the outputs, because it passes through the pending register first. Every scenario task drives its inputs on a falling edge and waits the exact number of rising edges before it samples on a later falling edge. In the latency cases it also samples one edge early to confirm that the old output is still held. Register reads are sampled shortly after the address settles, away from any rising edge.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
   // register port address map (control registers sit at their source number)
   localparam int unsigned A_MASK = 16;
   localparam int unsigned A_PEND = 17;
   localparam int unsigned A_SOFT = 18;
   localparam int unsigned A_SERA = 19;
   localparam int unsigned A_SERB = 20;

   // control register fields
   localparam int unsigned LVL_LSB  = 2;
   localparam int unsigned AUTO_BIT = 7;

   // reset value of the control register of source src
   function automatic logic [7:0] ctrl_reset_value(int src);
      if (src >= 1 && src <= 7)       return 8'(src * 4);
      else if (src == 8)              return 8'h1C;
      else if (src >= 9 && src <= 11) return 8'h80;
      else                            return 8'h00;
   endfunction
endpackage

// File: rtl/pvic_regs.sv
module pvic_regs
   import pvic_pkg::*;
#(
   parameter int NUM_SRC  = 13,
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 5,
   parameter int CTRL_W   = 8,
   parameter int PRIO_W   = 5,
   parameter int VEC_W    = 8,
   parameter logic [VEC_W-1:0] VEC_RST = 8'h0F
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NUM_SRC:1]                 irq_src,
   input  logic                             we,
   input  logic [ADDR_W-1:0]                addr,
   input  logic [DATA_W-1:0]                wdata,
   output logic [DATA_W-1:0]                rdata,
   output logic [NUM_SRC:1]                 pend_q,
   output logic [NUM_SRC:1]                 mask_q,
   output logic [NUM_SRC:1][PRIO_W-1:0]     prio_q,
   output logic [NUM_SRC:1]                 auto_q,
   output logic [VEC_W-1:0]                 soft_vec_q,
   output logic [VEC_W-1:0]                 sera_vec_q,
   output logic [VEC_W-1:0]                 serb_vec_q
);
   logic [NUM_SRC:1][CTRL_W-1:0] ctrl_q;
   logic                         unused_wdata;

   assign unused_wdata = ^wdata;

   for (genvar i = 1; i <= NUM_SRC; i++) begin : g_ctrl
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ctrl_q[i] <= CTRL_W'(ctrl_reset_value(i));
         else if (we && addr == ADDR_W'(i))
            ctrl_q[i] <= wdata[CTRL_W-1:0];
      end
      assign prio_q[i] = ctrl_q[i][PRIO_W-1:0];
      assign auto_q[i] = ctrl_q[i][AUTO_BIT];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q     <= '0;
         mask_q     <= '1;
         soft_vec_q <= VEC_RST;
         sera_vec_q <= VEC_RST;
         serb_vec_q <= VEC_RST;
      end else begin
         pend_q <= irq_src;
         if (we) begin
            if (addr == ADDR_W'(A_MASK)) mask_q     <= wdata[NUM_SRC:1];
            if (addr == ADDR_W'(A_SOFT)) soft_vec_q <= wdata[VEC_W-1:0];
            if (addr == ADDR_W'(A_SERA)) sera_vec_q <= wdata[VEC_W-1:0];
            if (addr == ADDR_W'(A_SERB)) serb_vec_q <= wdata[VEC_W-1:0];
         end
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 1; i <= NUM_SRC; i++)
         if (addr == ADDR_W'(i)) rdata[CTRL_W-1:0] = ctrl_q[i];
      if (addr == ADDR_W'(A_MASK)) rdata[NUM_SRC:1] = mask_q;
      if (addr == ADDR_W'(A_PEND)) rdata[NUM_SRC:1] = pend_q;
      if (addr == ADDR_W'(A_SOFT)) rdata[VEC_W-1:0] = soft_vec_q;
      if (addr == ADDR_W'(A_SERA)) rdata[VEC_W-1:0] = sera_vec_q;
      if (addr == ADDR_W'(A_SERB)) rdata[VEC_W-1:0] = serb_vec_q;
   end
endmodule

// File: rtl/pvic_arbiter.sv
module pvic_arbiter
   import pvic_pkg::*;
#(
   parameter int NUM_SRC    = 13,
   parameter int PRIO_W     = 5,
   parameter int CUTOFF     = 4,
   parameter bit TIE_TO_LOW = 1'b1,
   localparam int SRC_W     = $clog2(NUM_SRC + 1),
   localparam int LVL_W     = PRIO_W - LVL_LSB
) (
   input  logic [NUM_SRC:1]             pend,
   input  logic [NUM_SRC:1]             mask,
   input  logic [NUM_SRC:1][PRIO_W-1:0] prio,
   input  logic [NUM_SRC:1]             auto_sel,
   output logic                         win_valid,
   output logic [SRC_W-1:0]             win_src,
   output logic [LVL_W-1:0]             win_level,
   output logic                         win_auto
);
   logic [NUM_SRC:1]  active;
   logic [PRIO_W-1:0] best;

   assign active = pend & ~mask;

   if (TIE_TO_LOW) begin : g_tie_low
      always_comb begin
         best     = '0;
         win_src  = '0;
         win_auto = 1'b0;
         for (int i = 1; i <= NUM_SRC; i++)
            if (active[i] && prio[i] > best) begin
               best     = prio[i];
               win_src  = SRC_W'(i);
               win_auto = auto_sel[i];
            end
      end
   end else begin : g_tie_high
      always_comb begin
         best     = '0;
         win_src  = '0;
         win_auto = 1'b0;
         for (int i = 1; i <= NUM_SRC; i++)
            if (active[i] && prio[i] >= best) begin
               best     = prio[i];
               win_src  = SRC_W'(i);
               win_auto = auto_sel[i];
            end
      end
   end

   assign win_valid = (best >= PRIO_W'(CUTOFF));
   assign win_level = best[PRIO_W-1:LVL_LSB];
endmodule

// File: rtl/pvic_vecgen.sv
module pvic_vecgen #(
   parameter int NUM_SRC   = 13,
   parameter int LVL_W     = 3,
   parameter int VEC_W     = 8,
   parameter int AUTO_BASE = 24,
   parameter int SOFT_SRC  = 8,
   parameter int SERA_SRC  = 12,
   parameter int SERB_SRC  = 13,
   parameter logic [VEC_W-1:0] FALLBACK_VEC = 8'h0F,
   localparam int SRC_W    = $clog2(NUM_SRC + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               win_valid,
   input  logic [SRC_W-1:0]   win_src,
   input  logic [LVL_W-1:0]   win_level,
   input  logic               win_auto,
   input  logic [VEC_W-1:0]   soft_vec,
   input  logic [VEC_W-1:0]   sera_vec,
   input  logic [VEC_W-1:0]   serb_vec,
   output logic [LVL_W-1:0]   int_level,
   output logic [VEC_W-1:0]   int_vector
);
   logic [LVL_W-1:0] lvl_d;
   logic [VEC_W-1:0] vec_d;

   always_comb begin
      lvl_d = '0;
      vec_d = '0;
      if (win_valid) begin
         lvl_d = win_level;
         if (win_auto)                         vec_d = VEC_W'(AUTO_BASE) + VEC_W'(win_level);
         else if (win_src == SRC_W'(SOFT_SRC)) vec_d = soft_vec;
         else if (win_src == SRC_W'(SERA_SRC)) vec_d = sera_vec;
         else if (win_src == SRC_W'(SERB_SRC)) vec_d = serb_vec;
         else                                  vec_d = FALLBACK_VEC;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         int_level  <= '0;
         int_vector <= '0;
      end else begin
         int_level  <= lvl_d;
         int_vector <= vec_d;
      end
   end
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
   import pvic_pkg::*;
#(
   parameter int NUM_SRC    = 13,
   parameter int DATA_W     = 16,
   parameter int ADDR_W     = 5,
   parameter int CTRL_W     = 8,
   parameter int PRIO_W     = 5,
   parameter int VEC_W      = 8,
   parameter int CUTOFF     = 4,
   parameter int AUTO_BASE  = 24,
   parameter int SOFT_SRC   = 8,
   parameter int SERA_SRC   = 12,
   parameter int SERB_SRC   = 13,
   parameter bit TIE_TO_LOW = 1'b1,
   localparam int LVL_W     = PRIO_W - LVL_LSB,
   localparam int SRC_W     = $clog2(NUM_SRC + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC:1]   irq_src,
   input  logic               reg_we,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   output logic [LVL_W-1:0]   int_level,
   output logic [VEC_W-1:0]   int_vector
);
   if (NUM_SRC < 1 || NUM_SRC >= int'(A_MASK)) begin : g_bad_nsrc
      $error("NUM_SRC must lie in 1..15");
   end
   if (DATA_W < NUM_SRC + 1 || DATA_W < CTRL_W || DATA_W < VEC_W) begin : g_bad_dw
      $error("DATA_W too narrow for the registers");
   end
   if ((1 << ADDR_W) <= int'(A_SERB)) begin : g_bad_aw
      $error("ADDR_W cannot reach the vector registers");
   end
   if (CTRL_W <= int'(AUTO_BIT) || PRIO_W <= int'(LVL_LSB) || PRIO_W > CTRL_W) begin : g_bad_ctrl
      $error("control field layout does not fit CTRL_W");
   end
   if (CUTOFF < 1 || AUTO_BASE + (1 << LVL_W) > (1 << VEC_W)) begin : g_bad_vec
      $error("CUTOFF or AUTO_BASE out of range");
   end

   logic [NUM_SRC:1]             pend_q;
   logic [NUM_SRC:1]             mask_q;
   logic [NUM_SRC:1][PRIO_W-1:0] prio_q;
   logic [NUM_SRC:1]             auto_q;
   logic [VEC_W-1:0]             soft_vec_q, sera_vec_q, serb_vec_q;
   logic                         win_valid;
   logic [SRC_W-1:0]             win_src;
   logic [LVL_W-1:0]             win_level;
   logic                         win_auto;

   pvic_regs #(
      .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
      .CTRL_W(CTRL_W), .PRIO_W(PRIO_W), .VEC_W(VEC_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .irq_src(irq_src),
      .we(reg_we), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
      .pend_q(pend_q), .mask_q(mask_q), .prio_q(prio_q), .auto_q(auto_q),
      .soft_vec_q(soft_vec_q), .sera_vec_q(sera_vec_q), .serb_vec_q(serb_vec_q)
   );

   pvic_arbiter #(
      .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .CUTOFF(CUTOFF), .TIE_TO_LOW(TIE_TO_LOW)
   ) u_arb (
      .pend(pend_q), .mask(mask_q), .prio(prio_q), .auto_sel(auto_q),
      .win_valid(win_valid), .win_src(win_src), .win_level(win_level), .win_auto(win_auto)
   );

   pvic_vecgen #(
      .NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .VEC_W(VEC_W), .AUTO_BASE(AUTO_BASE),
      .SOFT_SRC(SOFT_SRC), .SERA_SRC(SERA_SRC), .SERB_SRC(SERB_SRC)
   ) u_vec (
      .clk(clk), .rst_n(rst_n),
      .win_valid(win_valid), .win_src(win_src), .win_level(win_level), .win_auto(win_auto),
      .soft_vec(soft_vec_q), .sera_vec(sera_vec_q), .serb_vec(serb_vec_q),
      .int_level(int_level), .int_vector(int_vector)
   );
endmodule

// File: rtl/prio_vec_intc_checker.sv
module prio_vec_intc_checker #(
   parameter int NUM_SRC   = 13,
   parameter int LVL_W     = 3,
   parameter int VEC_W     = 8,
   parameter int AUTO_BASE = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NUM_SRC:1] pend,
   input logic [NUM_SRC:1] mask,
   input logic             win_valid,
   input logic [LVL_W-1:0] win_level,
   input logic             win_auto,
   input logic [LVL_W-1:0] int_level,
   input logic [VEC_W-1:0] int_vector
);
   // R6: no level means no vector
   assert_idle_no_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
      int_level == '0 |-> int_vector == '0);

   // R3: nothing unmasked and pending -> no request on the next edge
   assert_masked_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pend & ~mask) == '0 |=> int_level == '0);

   // R3: a presented level was backed by an unmasked pending source
   assert_level_has_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
      int_level != '0 |-> $past(|(pend & ~mask)));

   // R11: the arbitration result appears one edge later
   assert_level_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |=> int_level == $past(win_level));

   assert_idle_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !win_valid |=> int_level == '0);

   // R8: autovector base plus level
   assert_autovector_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid && win_auto) |=> int_vector == VEC_W'(AUTO_BASE) + VEC_W'(int_level));
endmodule

bind prio_vec_intc prio_vec_intc_checker #(
   .NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .VEC_W(VEC_W), .AUTO_BASE(AUTO_BASE)
) u_checker (
   .clk(clk), .rst_n(rst_n), .pend(pend_q), .mask(mask_q),
   .win_valid(win_valid), .win_level(win_level), .win_auto(win_auto),
   .int_level(int_level), .int_vector(int_vector)
);

// File: tb/prio_vec_intc_bench.sv
module prio_vec_intc_bench;
   localparam time CLK_PERIOD = 10ns;
   localparam int  WATCHDOG   = 5000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [13:1] irq_src = '0;
   logic        reg_we = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [2:0]  int_level;
   logic [7:0]  int_vector;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   prio_vec_intc u_prio_vec_intc (
      .clk(clk), .rst_n(rst_n), .irq_src(irq_src),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .int_level(int_level), .int_vector(int_vector)
   );

   function automatic logic [7:0] exp_ctrl(int n);
      case (n)
         1: return 8'h04;  2: return 8'h08;  3: return 8'h0C;  4: return 8'h10;
         5: return 8'h14;  6: return 8'h18;  7: return 8'h1C;  8: return 8'h1C;
         9, 10, 11: return 8'h80;
         default: return 8'h00;
      endcase
   endfunction

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [4:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [15:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic expect_out(input string req, input int lvl, input int vec);
      check(req, "level", int'(int_level), lvl);
      check(req, "vector", int'(int_vector), vec);
   endtask

   task automatic t_reset();
      logic [15:0] d;
      expect_out("R1", 0, 0);
      for (int n = 1; n <= 13; n++) begin
         rd(5'(n), d);
         check("R1", $sformatf("ctrl %0d", n), int'(d), int'(exp_ctrl(n)));
      end
      rd(5'h10, d); check("R1", "mask", int'(d), 16'h3FFE);
      rd(5'h12, d); check("R1", "soft vector", int'(d), 8'h0F);
      rd(5'h13, d); check("R1", "serial A vector", int'(d), 8'h0F);
      rd(5'h14, d); check("R1", "serial B vector", int'(d), 8'h0F);
   endtask

   task automatic t_mask_all();
      logic [15:0] d;
      irq_src = '1;
      step();
      rd(5'h11, d); check("R2", "pending", int'(d), 16'h3FFE);
      step();
      expect_out("R3", 0, 0);
   endtask

   task automatic t_single_fallback();
      wr(5'h10, 16'h3F7E);                 // only source 7 unmasked
      expect_out("R11", 0, 0);             // not yet visible
      step();
      expect_out("R7", 7, 8'h0F);          // R10 fallback vector
   endtask

   task automatic t_tie_and_soft();
      wr(5'h12, 16'h0040);
      wr(5'h10, 16'h3E7E);                 // sources 7 and 8, both 0x1C
      step();
      expect_out("R5", 7, 8'h0F);
      wr(5'h10, 16'h3EFE);                 // source 8 only
      step();
      expect_out("R9", 7, 8'h40);
   endtask

   task automatic t_priority_serial();
      wr(5'h13, 16'h0055);
      wr(5'd12, 16'h001F);
      wr(5'h10, 16'h2EFE);                 // sources 8 and 12
      step();
      expect_out("R4", 7, 8'h55);
      wr(5'h14, 16'h0066);
      wr(5'd13, 16'h001E);
      wr(5'h10, 16'h0EFE);                 // sources 8, 12, 13
      step();
      expect_out("R4", 7, 8'h55);
      wr(5'h10, 16'h1EFE);                 // sources 8 and 13
      step();
      expect_out("R9", 7, 8'h66);
   endtask

   task automatic t_autovector();
      wr(5'd9, 16'h0094);                  // prio 20, level 5, auto
      wr(5'h10, 16'h3DFE);                 // source 9 only
      step();
      expect_out("R8", 5, 29);
      wr(5'd9, 16'h009C);                  // level 7
      step();
      expect_out("R8", 7, 31);
   endtask

   task automatic t_cutoff();
      wr(5'h10, 16'h3FFC);                 // source 1 only, reset ctrl 0x04
      step();
      expect_out("R6", 1, 8'h0F);
      wr(5'd1, 16'h0003);
      step();
      expect_out("R6", 0, 0);
      wr(5'd1, 16'h0083);
      step();
      expect_out("R6", 0, 0);
   endtask

   task automatic t_unmapped();
      logic [15:0] d;
      wr(5'd1, 16'h0004);
      step();
      wr(5'h1F, 16'hFFFF);
      wr(5'h00, 16'hFFFF);
      wr(5'h11, 16'h0000);
      step();
      rd(5'h1F, d); check("R12", "read 0x1F", int'(d), 0);
      rd(5'h00, d); check("R12", "read 0x00", int'(d), 0);
      rd(5'h11, d); check("R12", "pending after write", int'(d), 16'h3FFE);
      rd(5'h10, d); check("R12", "mask after stray writes", int'(d), 16'h3FFC);
      expect_out("R12", 1, 8'h0F);
   endtask

   task automatic t_line_drop();
      logic [15:0] d;
      irq_src[1] = 1'b0;
      step();
      rd(5'h11, d); check("R2", "pending bit1 clear", int'(d), 16'h3FFC);
      expect_out("R11", 1, 8'h0F);         // one edge: still old value
      step();
      expect_out("R11", 0, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mask_all();
      t_single_fallback();
      t_tie_and_soft();
      t_priority_serial();
      t_autovector();
      t_cutoff();
      t_unmapped();
      t_line_drop();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL R11 watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule